// File: doc/BRIEF.md
# NAND strobe timing generator

This block drives the control strobes of a raw NAND flash interface for one byte at a time. A client presents a request for a data read, a data write, a command byte or an address byte. The block then walks through the phases of that access: chip enable is pulled low, the read or write strobe is pulsed, and for reads the byte on the bus is captured. Every phase length is set by its own field of one 32-bit timing word. The word is sampled when the request is accepted.

A request may also ask the block to wait for the flash after the strobe. In that case chip enable stays low for a programmed delay, during which the ready/busy pin is ignored. The block then waits until the pin reports ready. A one-cycle done pulse closes every access. When a byte is driven right after a read, the data bus output enable stays off for a programmed turnaround time, so the flash and the controller never drive the bus together.

Top module: `nand_strobe_gen`

## Requirements
- R1: After reset, and whenever no access is in progress, ce_n, re_n and we_n are high, cle, ale, dq_oe, rd_valid and done are low, and dq_out is zero.
- R2: The timing word holds these fields: write-low count in bits 3:0, write-high in 7:4, read-low in 11:8, read-high in 15:12, turnaround in 18:16, busy delay in 23:19 and chip-enable lead in 25:24. A field value of n lasts n clock cycles, and a value of zero lasts one cycle.
- R3: An access starts with a lead phase of chip-enable-lead cycles. In this phase ce_n is low, cle, ale, dq_oe and dq_out already hold their values for the access, and both strobes are high.
- R4: A read (req_kind 2'b00) holds re_n low for read-low cycles and then high for read-high cycles. The byte on dq_in is captured on the rising edge of re_n. rd_valid is high for exactly the first cycle of the high phase, and rd_data keeps the byte until the next read.
- R5: A data write (2'b01), a command (2'b10) and an address (2'b11) hold we_n low for write-low cycles and then high for write-high cycles. Through lead, low and high phases dq_oe is high and dq_out carries req_wdata. cle is high only for a command and ale is high only for an address.
- R6: When a write-type access follows a read, a turnaround phase of turnaround cycles comes first. In this phase ce_n is low, and dq_oe, cle and ale are low with both strobes high. There is no turnaround after a write-type access.
- R7: With req_wait set, after the strobe high phase ce_n stays low for busy-delay cycles with rb_n ignored. The block then samples rb_n on each clock and ends the access on the first edge at which it is high.
- R8: done is high for one cycle, with ce_n high, in the cycle after the last phase of each accepted access.
- R9: A request is accepted only when no access is in progress. req_valid during an access has no effect.
- R10: The timing word is sampled when the request is accepted. Changes during an access do not alter that access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timing_word | input | WORD_W | Packed phase lengths |
| req_valid | input | 1 | Start an access (taken when idle) |
| req_kind | input | 2 | 00 read, 01 write data, 10 command, 11 address |
| req_wdata | input | DATA_W | Byte to drive for write-type accesses |
| req_wait | input | 1 | Wait for busy delay and ready after the strobe |
| rb_n | input | 1 | Flash ready/busy, high when ready |
| dq_in | input | DATA_W | Flash data bus, incoming |
| ce_n | output | 1 | Chip enable, active low |
| re_n | output | 1 | Read strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| dq_out | output | DATA_W | Flash data bus, outgoing |
| dq_oe | output | 1 | Output enable for dq_out |
| rd_data | output | DATA_W | Last captured read byte |
| rd_valid | output | 1 | rd_data updated this cycle |
| done | output | 1 | Access finished |

## Verification
The bench builds the block with its default parameters: a 32-bit timing word and an 8-bit data bus. Every phase counter therefore spans its full field range. The bench drives an all-zero timing word to reach the zero-as-one rule, and a word with every field at its maximum to reach the widest counts: a three-cycle lead, fifteen-cycle strobes, a seven-cycle turnaround and a thirty-one-cycle busy delay. Read-then-write sequences reach the turnaround phase. Ready/busy held high through the delay, and ready/busy released late, reach both ends of the wait.

// File: rtl/nsg_pkg.sv
package nsg_pkg;

  localparam int CNT_W   = 5;
  localparam int FLD_NUM = 7;
  localparam int TW_USED = 26;

  localparam int FLD_WR_LO = 0;
  localparam int FLD_WR_HI = 1;
  localparam int FLD_RD_LO = 2;
  localparam int FLD_RD_HI = 3;
  localparam int FLD_TA    = 4;
  localparam int FLD_BDLY  = 5;
  localparam int FLD_TCEA  = 6;

  typedef logic [FLD_NUM-1:0][CNT_W-1:0] nsg_len_t;

  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_CMD   = 2'b10,
    KIND_ADDR  = 2'b11
  } nsg_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_BDLY,
    ST_WRB
  } nsg_state_e;

  function automatic int fld_lsb(int idx);
    case (idx)
      FLD_WR_LO: return 0;
      FLD_WR_HI: return 4;
      FLD_RD_LO: return 8;
      FLD_RD_HI: return 12;
      FLD_TA:    return 16;
      FLD_BDLY:  return 19;
      default:   return 24;
    endcase
  endfunction

  function automatic int fld_width(int idx);
    case (idx)
      FLD_TA:   return 3;
      FLD_BDLY: return 5;
      FLD_TCEA: return 2;
      default:  return 4;
    endcase
  endfunction

endpackage

// File: rtl/nsg_rst_sync.sv
module nsg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/nsg_field_unpack.sv
module nsg_field_unpack
  import nsg_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word,
  output nsg_len_t          len_m1
);
  logic unused_hi_bits;
  assign unused_hi_bits = ^word[WORD_W-1:TW_USED];

  for (genvar g = 0; g < FLD_NUM; g++) begin : g_fld
    localparam int L = fld_lsb(g);
    localparam int W = fld_width(g);
    logic [CNT_W-1:0] raw;
    always_comb begin
      raw        = '0;
      raw[W-1:0] = word[L +: W];
    end
    assign len_m1[g] = (raw == '0) ? '0 : raw - CNT_W'(1);
  end
endmodule

// File: rtl/nsg_phase_cnt.sv
module nsg_phase_cnt #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - W'(1);
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/nsg_seq.sv
module nsg_seq
  import nsg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_wait,
  input  nsg_len_t          len_in,
  input  logic              rb_n,
  input  logic [DATA_W-1:0] dq_in,
  output logic              ce_n,
  output logic              re_n,
  output logic              we_n,
  output logic              cle,
  output logic              ale,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              done
);
  nsg_state_e        state_q, state_d;
  nsg_kind_e         kind_q;
  logic [DATA_W-1:0] data_q;
  logic              wait_q;
  logic              last_rd_q;
  nsg_len_t          cfg_q;
  logic              done_q, done_d;
  logic              rdv_q;
  logic [DATA_W-1:0] rdata_q;

  logic              cnt_load;
  logic [CNT_W-1:0]  cnt_val;
  logic              cnt_zero;
  logic              accept;
  logic              capture;
  logic              is_rd;
  logic              in_access;
  nsg_kind_e         req_kind_e;

  assign req_kind_e = nsg_kind_e'(req_kind);
  assign accept     = (state_q == ST_IDLE) && req_valid;
  assign is_rd      = (kind_q == KIND_READ);
  assign capture    = (state_q == ST_LOW) && cnt_zero && is_rd;

  nsg_phase_cnt #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  // next state and phase length selection
  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    done_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          cnt_load = 1'b1;
          if ((req_kind_e != KIND_READ) && last_rd_q) begin
            state_d = ST_TURN;
            cnt_val = len_in[FLD_TA];
          end else begin
            state_d = ST_SETUP;
            cnt_val = len_in[FLD_TCEA];
          end
        end
      end
      ST_TURN: begin
        if (cnt_zero) begin
          state_d  = ST_SETUP;
          cnt_load = 1'b1;
          cnt_val  = cfg_q[FLD_TCEA];
        end
      end
      ST_SETUP: begin
        if (cnt_zero) begin
          state_d  = ST_LOW;
          cnt_load = 1'b1;
          cnt_val  = is_rd ? cfg_q[FLD_RD_LO] : cfg_q[FLD_WR_LO];
        end
      end
      ST_LOW: begin
        if (cnt_zero) begin
          state_d  = ST_HIGH;
          cnt_load = 1'b1;
          cnt_val  = is_rd ? cfg_q[FLD_RD_HI] : cfg_q[FLD_WR_HI];
        end
      end
      ST_HIGH: begin
        if (cnt_zero) begin
          if (wait_q) begin
            state_d  = ST_BDLY;
            cnt_load = 1'b1;
            cnt_val  = cfg_q[FLD_BDLY];
          end else begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      ST_BDLY: begin
        if (cnt_zero) state_d = ST_WRB;
      end
      ST_WRB: begin
        if (rb_n) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      rdv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      rdv_q   <= capture;
    end
  end

  // request snapshot, enabled by accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q    <= KIND_READ;
      data_q    <= '0;
      wait_q    <= 1'b0;
      last_rd_q <= 1'b0;
      cfg_q     <= '0;
    end else if (accept) begin
      kind_q    <= req_kind_e;
      data_q    <= req_wdata;
      wait_q    <= req_wait;
      last_rd_q <= (req_kind_e == KIND_READ);
      cfg_q     <= len_in;
    end
  end

  // read byte capture, enabled at the rising read strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= dq_in;
  end

  assign in_access = (state_q == ST_SETUP) || (state_q == ST_LOW) ||
                     (state_q == ST_HIGH);
  assign ce_n      = (state_q == ST_IDLE);
  assign re_n      = !((state_q == ST_LOW) && is_rd);
  assign we_n      = !((state_q == ST_LOW) && !is_rd);
  assign cle       = in_access && (kind_q == KIND_CMD);
  assign ale       = in_access && (kind_q == KIND_ADDR);
  assign dq_oe     = in_access && !is_rd;
  assign dq_out    = dq_oe ? data_q : '0;
  assign rd_data   = rdata_q;
  assign rd_valid  = rdv_q;
  assign done      = done_q;
endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
  import nsg_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] timing_word,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_wait,
  input  logic              rb_n,
  input  logic [DATA_W-1:0] dq_in,
  output logic              ce_n,
  output logic              re_n,
  output logic              we_n,
  output logic              cle,
  output logic              ale,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              done
);
  logic     rst_sync_n;
  nsg_len_t len_m1;

  nsg_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  nsg_field_unpack #(.WORD_W(WORD_W)) u_unpack (
    .word   (timing_word),
    .len_m1 (len_m1)
  );

  nsg_seq #(.DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_wdata (req_wdata),
    .req_wait  (req_wait),
    .len_in    (len_m1),
    .rb_n      (rb_n),
    .dq_in     (dq_in),
    .ce_n      (ce_n),
    .re_n      (re_n),
    .we_n      (we_n),
    .cle       (cle),
    .ale       (ale),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .done      (done)
  );
endmodule

// File: rtl/nsg_checker.sv
module nsg_checker (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic re_n,
  input logic we_n,
  input logic cle,
  input logic ale,
  input logic dq_oe,
  input logic rd_valid,
  input logic done
);
  // R1: with chip enable released, nothing is strobed or driven
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (re_n && we_n && !dq_oe && !cle && !ale));

  // R3: a strobe only falls after chip enable was already low
  a_r3_ce_leads_re: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(re_n) |-> $past(!ce_n));
  a_r3_ce_leads_we: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> $past(!ce_n));

  // R4: read data is flagged in the cycle re_n rises
  a_r4_capture_edge: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $rose(re_n));

  // R5: strobes exclusive, latch enables exclusive, bus driven while writing
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!re_n, !we_n}) <= 1);
  a_r5_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cle, ale}));
  a_r5_we_drives: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> dq_oe);

  // R8: done follows an active access and finds chip enable released
  a_r8_done_shape: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ce_n && $past(!ce_n)));
endmodule

bind nand_strobe_gen nsg_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .ce_n     (ce_n),
  .re_n     (re_n),
  .we_n     (we_n),
  .cle      (cle),
  .ale      (ale),
  .dq_oe    (dq_oe),
  .rd_valid (rd_valid),
  .done     (done)
);

// File: tb/tb_nand_strobe_gen.sv
`timescale 1ns/1ps
module tb_nand_strobe_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] timing_word;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [7:0]  req_wdata;
  logic        req_wait;
  logic        rb_n;
  logic [7:0]  dq_in;
  logic        ce_n, re_n, we_n, cle, ale, dq_oe, rd_valid, done;
  logic [7:0]  dq_out, rd_data;

  always #2.5 clk = ~clk;

  nand_strobe_gen dut (
    .clk(clk), .rst_n(rst_n), .timing_word(timing_word),
    .req_valid(req_valid), .req_kind(req_kind), .req_wdata(req_wdata),
    .req_wait(req_wait), .rb_n(rb_n), .dq_in(dq_in),
    .ce_n(ce_n), .re_n(re_n), .we_n(we_n), .cle(cle), .ale(ale),
    .dq_out(dq_out), .dq_oe(dq_oe), .rd_data(rd_data),
    .rd_valid(rd_valid), .done(done)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_req = "R1";
  bit    chk_en  = 0;
  int    cyc     = 0;
  int    n_acc   = 0;
  int    n_done  = 0;

  // vector: ce_n re_n we_n cle ale oe dq[7:0] rd_valid done
  function automatic logic [15:0] mkv(bit c, bit r, bit w, bit cl, bit al,
                                      bit oe, logic [7:0] dq, bit rv, bit dn);
    return {c, r, w, cl, al, oe, dq, rv, dn};
  endfunction

  function automatic int eff(int n);
    return (n == 0) ? 1 : n;
  endfunction

  function automatic logic [31:0] mkw(int tcea, int bdly, int ta, int rh,
                                      int rl, int wh, int wl);
    logic [31:0] w;
    w = '0;
    w[25:24] = 2'(tcea); w[23:19] = 5'(bdly); w[18:16] = 3'(ta);
    w[15:12] = 4'(rh);   w[11:8]  = 4'(rl);   w[7:4]   = 4'(wh);
    w[3:0]   = 4'(wl);
    return w;
  endfunction

  localparam logic [15:0] IDLE_V = 16'b1110_0000_0000_0000;
  localparam logic [15:0] DONE_V = 16'b1110_0000_0000_0001;
  localparam logic [15:0] WRB_V  = 16'b0110_0000_0000_0000;

  logic [16:0] mq[$];
  logic [7:0]  rdq[$];
  int          pend = 0;
  bit          last_rd = 0;
  logic [15:0] exp_v = IDLE_V;
  logic [7:0]  exp_rd = 8'h00;
  logic [16:0] ent;

  task automatic build(logic [1:0] k, logic [7:0] d, bit wt, logic [31:0] tw);
    bit rd = (k == 2'b00);
    bit cl = (k == 2'b10);
    bit al = (k == 2'b11);
    logic [7:0] dq = rd ? 8'h00 : d;
    int nlo = rd ? eff(int'(tw[11:8]))  : eff(int'(tw[3:0]));
    int nhi = rd ? eff(int'(tw[15:12])) : eff(int'(tw[7:4]));
    if (!rd && last_rd)
      for (int i = 0; i < eff(int'(tw[18:16])); i++) mq.push_back({1'b0, WRB_V});
    for (int i = 0; i < eff(int'(tw[25:24])); i++)
      mq.push_back({1'b0, mkv(0, 1, 1, cl, al, !rd, dq, 0, 0)});
    for (int i = 0; i < nlo; i++)
      mq.push_back({1'b0, mkv(0, !rd, rd, cl, al, !rd, dq, 0, 0)});
    for (int i = 0; i < nhi; i++)
      mq.push_back({1'b0, mkv(0, 1, 1, cl, al, !rd, dq, rd && (i == 0), 0)});
    if (wt) begin
      for (int i = 0; i < eff(int'(tw[23:19])); i++)
        mq.push_back({(i == eff(int'(tw[23:19])) - 1), WRB_V});
    end else begin
      mq.push_back({1'b0, DONE_V});
    end
    if (rd) rdq.push_back(dq_in);
    last_rd = rd;
    n_acc++;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); rdq.delete(); pend = 0; last_rd = 0; exp_v = IDLE_V;
    end else begin
      if (mq.size() == 0 && pend == 0 && req_valid)
        build(req_kind, req_wdata, req_wait, timing_word);
      if (mq.size() > 0) begin
        ent = mq.pop_front();
        exp_v = ent[15:0];
        if (ent[16]) pend = 2;
        if (ent[1]) exp_rd = rdq.pop_front();
      end else if (pend == 2) begin
        exp_v = WRB_V; pend = 1;
      end else if (pend == 1) begin
        if (rb_n) begin exp_v = DONE_V; pend = 0; end
        else exp_v = WRB_V;
      end else begin
        exp_v = IDLE_V;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (done) n_done++;
    if (chk_en) begin
      check(cur_req, 32'({ce_n, re_n, we_n, cle, ale, dq_oe, dq_out, rd_valid, done}),
            32'(exp_v));
      if (exp_v[1]) check("R4", 32'(rd_data), 32'(exp_rd));
    end
  end

  function automatic bit model_idle();
    return (mq.size() == 0) && (pend == 0);
  endfunction

  task automatic start(logic [1:0] k, logic [7:0] d, bit wt);
    @(negedge clk);
    req_kind = k; req_wdata = d; req_wait = wt; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run(logic [1:0] k, logic [7:0] d, bit wt);
    start(k, d, wt);
    while (!model_idle()) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; timing_word = '0; req_valid = 1'b0; req_kind = 2'b00;
    req_wdata = 8'h00; req_wait = 1'b0; rb_n = 1'b1; dq_in = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check("R1", 32'({ce_n, re_n, we_n, cle, ale, dq_oe, dq_out, rd_valid, done}),
          32'(IDLE_V));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_en = 1;

    // R5: write data, command, address
    timing_word = mkw(2, 3, 2, 2, 3, 3, 2);
    cur_req = "R5"; run(2'b01, 8'h3C, 0);
    cur_req = "R5"; run(2'b10, 8'h90, 0);
    cur_req = "R5"; run(2'b11, 8'h12, 0);
    // R3: longest lead with a command byte
    timing_word = mkw(3, 1, 1, 1, 1, 1, 1);
    cur_req = "R3"; run(2'b10, 8'h70, 0);

    // R4: reads with captured byte
    timing_word = mkw(1, 2, 3, 2, 3, 1, 1);
    dq_in = 8'hA5;
    cur_req = "R4"; run(2'b00, 8'h00, 0);
    check("R4", 32'(rd_data), 32'h0000_00A5);
    dq_in = 8'h5A;
    cur_req = "R4"; run(2'b00, 8'h00, 0);
    check("R4", 32'(rd_data), 32'h0000_005A);

    // R6: write after read gets turnaround, write after write does not
    cur_req = "R6"; run(2'b01, 8'hC3, 0);
    cur_req = "R6"; run(2'b11, 8'h44, 0);
    timing_word = mkw(1, 1, 7, 1, 1, 1, 1);
    cur_req = "R6"; run(2'b00, 8'h00, 0);
    cur_req = "R6"; run(2'b10, 8'h60, 0);

    // R2: all fields zero, then all fields at maximum
    timing_word = '0;
    cur_req = "R2"; run(2'b00, 8'h00, 0);
    cur_req = "R2"; run(2'b01, 8'hF0, 1);
    timing_word = mkw(3, 31, 7, 15, 15, 15, 15);
    dq_in = 8'h81;
    cur_req = "R2"; run(2'b00, 8'h00, 0);
    cur_req = "R2"; run(2'b01, 8'h0F, 1);

    // R7: ready high during busy delay is ignored, then late ready
    timing_word = mkw(1, 4, 1, 1, 1, 2, 2);
    rb_n = 1'b1;
    cur_req = "R7"; run(2'b10, 8'h10, 1);
    rb_n = 1'b0;
    cur_req = "R7"; start(2'b10, 8'hD0, 1);
    repeat (20) @(negedge clk);
    rb_n = 1'b1;
    while (!model_idle()) @(negedge clk);
    @(negedge clk);

    // R9: requests during an access are ignored
    timing_word = mkw(2, 1, 1, 4, 4, 4, 4);
    cur_req = "R9"; start(2'b01, 8'h77, 0);
    @(negedge clk); req_kind = 2'b10; req_wdata = 8'hEE; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    repeat (3) @(negedge clk); req_kind = 2'b00; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    while (!model_idle()) @(negedge clk);
    @(negedge clk);

    // R10: timing word changes mid-access
    timing_word = mkw(2, 1, 1, 3, 3, 3, 3);
    cur_req = "R10"; start(2'b01, 8'hAB, 0);
    timing_word = mkw(0, 0, 0, 9, 9, 9, 9);
    while (!model_idle()) @(negedge clk);
    @(negedge clk);

    // R8: one done pulse per accepted access
    repeat (3) @(negedge clk);
    check("R8", 32'(n_done), 32'(n_acc));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule